// File: doc/BRIEF.md
# Saturating PHY Error Event Counters

This block keeps two 8-bit management counters for a physical-layer receiver. The first counts false-carrier events. The second counts receive symbol errors, at most once per carrier event. Each counter stops at its all-ones value instead of wrapping. A management agent may load either counter, and reading a counter clears it.

Each counter also drives an error-seen latch bit and a half-full event pulse. The latch bit is set by the counter's event and stays set until that same counter is read. The half-full pulse marks the moment the counter first crosses into its upper half, and it feeds an interrupt controller elsewhere on the chip. Symbol decoding and carrier detection happen upstream: this block receives only their results, as pulses and levels.

Top module: `phy_err_counters`

## Requirements
- R1: Every cycle in which `fc_event_i` is high adds 1 to `fc_count_o`, seen on the next cycle, unless a write, a read or saturation applies.
- R2: Both counters hold at 8'hFF once they reach it: further events leave the value at 8'hFF and never wrap to 0.
- R3: `rx_count_o` adds 1 for a cycle with `carrier_ok_i`, `bad_sym_i` and no collision. After that it counts nothing more until `carrier_ok_i` has been low for at least one cycle.
- R4: A `bad_sym_i` pulse while `collision_i` is high is not counted. It also does not use up the single count allowed for the current carrier event.
- R5: A cycle with `mgmt_wr_en_i` high loads `mgmt_wr_data_i` into the counter chosen by `mgmt_wr_sel_i` (0 = false-carrier, 1 = receive-error), seen on the next cycle. The write takes priority over a read or an event on that counter in the same cycle. The other counter is unaffected.
- R6: A read strobe (`fc_rd_i` or `rx_rd_i`) clears its counter to 0 on the next cycle. If a counted event arrives in the same cycle as the read, the counter becomes 1 instead.
- R7: `fc_seen_o` and `rx_seen_o` are set by their counter's counted event, including when the counter is saturated or is being written. Each clears only on a read of its own counter, and an event in the same cycle as that read keeps it set. A write or a read of the other counter leaves it unchanged.
- R8: `fc_half_o` or `rx_half_o` is high for exactly one cycle: the cycle in which the counter first shows 8'h80 after an event incremented it from 8'h7F. A write of 8'h80 does not produce the pulse.
- R9: After reset both counters, both latch bits and both half-full pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_event_i | input | 1 | False-carrier event pulse, one per cycle high |
| carrier_ok_i | input | 1 | Level: a valid carrier is present |
| bad_sym_i | input | 1 | Invalid data symbol pulse |
| collision_i | input | 1 | Level: a collision is present |
| mgmt_wr_en_i | input | 1 | Management write strobe |
| mgmt_wr_sel_i | input | 1 | Write target: 0 false-carrier, 1 receive-error |
| mgmt_wr_data_i | input | 8 | Value to load |
| fc_rd_i | input | 1 | Read strobe of the false-carrier counter |
| rx_rd_i | input | 1 | Read strobe of the receive-error counter |
| fc_count_o | output | 8 | False-carrier counter value |
| rx_count_o | output | 8 | Receive-error counter value |
| fc_seen_o | output | 1 | False-carrier event latch |
| rx_seen_o | output | 1 | Receive-error event latch |
| fc_half_o | output | 1 | False-carrier half-full event pulse |
| rx_half_o | output | 1 | Receive-error half-full event pulse |

## Verification
Bursts of back-to-back false-carrier pulses, started from loaded values near 8'h7F and 8'hFF, separate the correct half-full crossing and saturation from a wrap or an off-by-one. Receive errors repeated within one carrier, then across a carrier drop, separate counting once per carrier from counting once per symbol. Errors during a collision, followed by a clean error in the same carrier, check that collision errors neither count nor use up the carrier's single count. A long random phase mixes writes, reads, carrier edges and collisions in the same cycles, so that the priority of write over read over increment is compared on every clock.

// File: rtl/phy_errcnt_pkg.sv
package phy_errcnt_pkg;

    // Default counter width shared by every instance
    localparam int ERRCNT_W = 8;

    // Channel numbering; also the value of the write select port
    localparam int NUM_CH = 2;

    typedef enum logic {
        CH_FALSE_CARRIER = 1'b0,
        CH_RX_ERROR      = 1'b1
    } errcnt_ch_e;

endpackage

// File: rtl/phy_errcnt_rx_qual.sv
// Qualifies raw symbol errors into at most one counted event per carrier.
module phy_errcnt_rx_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_ok_i,
    input  logic bad_sym_i,
    input  logic collision_i,
    output logic event_o
);

    typedef struct packed {
        logic counted;   // this carrier event already produced a count
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d = st_q;
        hit  = carrier_ok_i && bad_sym_i && !collision_i && !st_q.counted;
        if (!carrier_ok_i) begin
            st_d.counted = 1'b0;
        end else if (hit) begin
            st_d.counted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o = hit;

endmodule

// File: rtl/phy_errcnt_sat_counter.sv
// One saturating, loadable, clear-on-read counter with event latch and
// half-full crossing pulse.
module phy_errcnt_sat_counter #(
    parameter int CNT_W = phy_errcnt_pkg::ERRCNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             seen_o,
    output logic             half_o
);

    localparam logic [CNT_W-1:0] CNT_MAX     = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_HALF    = CNT_MAX ^ (CNT_MAX >> 1);
    localparam logic [CNT_W-1:0] CNT_HALF_M1 = CNT_HALF - 1'b1;
    localparam logic [CNT_W-1:0] CNT_ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             half;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.half = 1'b0;

        // value: write > read > increment
        if (wr_i) begin
            st_d.cnt = wr_data_i;
        end else if (rd_i) begin
            st_d.cnt = inc_i ? CNT_ONE : '0;
        end else if (inc_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.half = (st_q.cnt == CNT_HALF_M1);
        end

        // latch: set beats clear
        if (inc_i) begin
            st_d.seen = 1'b1;
        end else if (rd_i) begin
            st_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign seen_o  = st_q.seen;
    assign half_o  = st_q.half;

endmodule

// File: rtl/phy_err_counters.sv
module phy_err_counters #(
    parameter int CNT_W = phy_errcnt_pkg::ERRCNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_event_i,
    input  logic             carrier_ok_i,
    input  logic             bad_sym_i,
    input  logic             collision_i,
    input  logic             mgmt_wr_en_i,
    input  logic             mgmt_wr_sel_i,
    input  logic [CNT_W-1:0] mgmt_wr_data_i,
    input  logic             fc_rd_i,
    input  logic             rx_rd_i,
    output logic [CNT_W-1:0] fc_count_o,
    output logic [CNT_W-1:0] rx_count_o,
    output logic             fc_seen_o,
    output logic             rx_seen_o,
    output logic             fc_half_o,
    output logic             rx_half_o
);

    import phy_errcnt_pkg::*;

    logic                 rx_event;
    logic [NUM_CH-1:0]    ch_inc;
    logic [NUM_CH-1:0]    ch_rd;
    logic [NUM_CH-1:0]    ch_wr;
    logic [NUM_CH-1:0]    ch_seen;
    logic [NUM_CH-1:0]    ch_half;
    logic [CNT_W-1:0]     ch_cnt [NUM_CH];

    phy_errcnt_rx_qual u_rx_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .carrier_ok_i (carrier_ok_i),
        .bad_sym_i    (bad_sym_i),
        .collision_i  (collision_i),
        .event_o      (rx_event)
    );

    assign ch_inc[CH_FALSE_CARRIER] = fc_event_i;
    assign ch_inc[CH_RX_ERROR]      = rx_event;
    assign ch_rd[CH_FALSE_CARRIER]  = fc_rd_i;
    assign ch_rd[CH_RX_ERROR]       = rx_rd_i;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign ch_wr[g] = mgmt_wr_en_i && (mgmt_wr_sel_i == 1'(g));

            phy_errcnt_sat_counter #(
                .CNT_W (CNT_W)
            ) u_ctr (
                .clk       (clk),
                .rst_n     (rst_n),
                .inc_i     (ch_inc[g]),
                .rd_i      (ch_rd[g]),
                .wr_i      (ch_wr[g]),
                .wr_data_i (mgmt_wr_data_i),
                .count_o   (ch_cnt[g]),
                .seen_o    (ch_seen[g]),
                .half_o    (ch_half[g])
            );
        end
    endgenerate

    assign fc_count_o = ch_cnt[CH_FALSE_CARRIER];
    assign rx_count_o = ch_cnt[CH_RX_ERROR];
    assign fc_seen_o  = ch_seen[CH_FALSE_CARRIER];
    assign rx_seen_o  = ch_seen[CH_RX_ERROR];
    assign fc_half_o  = ch_half[CH_FALSE_CARRIER];
    assign rx_half_o  = ch_half[CH_RX_ERROR];

endmodule

// File: rtl/phy_err_counters_chk.sv
module phy_err_counters_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fc_event_i,
    input logic             carrier_ok_i,
    input logic             collision_i,
    input logic             rx_event,
    input logic             mgmt_wr_en_i,
    input logic             mgmt_wr_sel_i,
    input logic [CNT_W-1:0] mgmt_wr_data_i,
    input logic             fc_rd_i,
    input logic             rx_rd_i,
    input logic [CNT_W-1:0] fc_count_o,
    input logic [CNT_W-1:0] rx_count_o,
    input logic             fc_seen_o,
    input logic             rx_seen_o,
    input logic             fc_half_o,
    input logic             rx_half_o
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HALF = MAXV ^ (MAXV >> 1);

    logic fc_wr, rx_wr;
    assign fc_wr = mgmt_wr_en_i && !mgmt_wr_sel_i;
    assign rx_wr = mgmt_wr_en_i &&  mgmt_wr_sel_i;

    assert_fc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fc_event_i && !fc_wr && !fc_rd_i && fc_count_o != MAXV
        |=> fc_count_o == CNT_W'($past(fc_count_o) + 1'b1));

    assert_fc_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fc_count_o == MAXV && !fc_wr && !fc_rd_i |=> fc_count_o == MAXV);

    assert_rx_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count_o == MAXV && !rx_wr && !rx_rd_i |=> rx_count_o == MAXV);

    assert_rx_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> !rx_event);

    assert_rx_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        collision_i && !rx_wr && !rx_rd_i |=> $stable(rx_count_o));

    assert_fc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fc_wr |=> fc_count_o == $past(mgmt_wr_data_i));

    assert_rx_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |=> rx_count_o == $past(mgmt_wr_data_i));

    assert_fc_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fc_rd_i && !fc_wr |=> fc_count_o == {{(CNT_W-1){1'b0}}, $past(fc_event_i)});

    assert_fc_seen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fc_seen_o && !fc_rd_i |=> fc_seen_o);

    assert_rx_seen_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |=> rx_seen_o);

    assert_fc_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fc_half_o |-> fc_count_o == HALF && !$stable(fc_count_o));

    assert_half_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_half_o |=> !fc_half_o) and (rx_half_o |=> !rx_half_o));

    assert_carrier_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok_i |-> !rx_event);

endmodule

bind phy_err_counters phy_err_counters_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fc_event_i     (fc_event_i),
    .carrier_ok_i   (carrier_ok_i),
    .collision_i    (collision_i),
    .rx_event       (rx_event),
    .mgmt_wr_en_i   (mgmt_wr_en_i),
    .mgmt_wr_sel_i  (mgmt_wr_sel_i),
    .mgmt_wr_data_i (mgmt_wr_data_i),
    .fc_rd_i        (fc_rd_i),
    .rx_rd_i        (rx_rd_i),
    .fc_count_o     (fc_count_o),
    .rx_count_o     (rx_count_o),
    .fc_seen_o      (fc_seen_o),
    .rx_seen_o      (rx_seen_o),
    .fc_half_o      (fc_half_o),
    .rx_half_o      (rx_half_o)
);

// File: tb/test_phy_err_counters.sv
`timescale 1ns/1ps
module test_phy_err_counters;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fc_event_i = 0, carrier_ok_i = 0, bad_sym_i = 0, collision_i = 0;
    logic       mgmt_wr_en_i = 0, mgmt_wr_sel_i = 0, fc_rd_i = 0, rx_rd_i = 0;
    logic [7:0] mgmt_wr_data_i = 0;
    logic [7:0] fc_count_o, rx_count_o;
    logic       fc_seen_o, rx_seen_o, fc_half_o, rx_half_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    int m_fc = 0, m_rx = 0;
    int m_fc_seen = 0, m_rx_seen = 0, m_fc_half = 0, m_rx_half = 0;
    int m_used = 0;

    always #2 clk = ~clk;

    phy_err_counters i_phy_err_counters (
        .clk(clk), .rst_n(rst_n),
        .fc_event_i(fc_event_i), .carrier_ok_i(carrier_ok_i),
        .bad_sym_i(bad_sym_i), .collision_i(collision_i),
        .mgmt_wr_en_i(mgmt_wr_en_i), .mgmt_wr_sel_i(mgmt_wr_sel_i),
        .mgmt_wr_data_i(mgmt_wr_data_i),
        .fc_rd_i(fc_rd_i), .rx_rd_i(rx_rd_i),
        .fc_count_o(fc_count_o), .rx_count_o(rx_count_o),
        .fc_seen_o(fc_seen_o), .rx_seen_o(rx_seen_o),
        .fc_half_o(fc_half_o), .rx_half_o(rx_half_o)
    );

    task automatic chk(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_step();
        bit rx_hit;
        bit fc_w, rx_w;
        fc_w   = mgmt_wr_en_i && !mgmt_wr_sel_i;
        rx_w   = mgmt_wr_en_i &&  mgmt_wr_sel_i;
        rx_hit = carrier_ok_i && bad_sym_i && !collision_i && (m_used == 0);
        m_fc_half = 0;
        m_rx_half = 0;
        if (fc_w) m_fc = mgmt_wr_data_i;
        else if (fc_rd_i) m_fc = fc_event_i ? 1 : 0;
        else if (fc_event_i && m_fc < 255) begin
            if (m_fc == 127) m_fc_half = 1;
            m_fc++;
        end
        if (rx_w) m_rx = mgmt_wr_data_i;
        else if (rx_rd_i) m_rx = rx_hit ? 1 : 0;
        else if (rx_hit && m_rx < 255) begin
            if (m_rx == 127) m_rx_half = 1;
            m_rx++;
        end
        if (fc_event_i) m_fc_seen = 1; else if (fc_rd_i) m_fc_seen = 0;
        if (rx_hit) m_rx_seen = 1; else if (rx_rd_i) m_rx_seen = 0;
        if (!carrier_ok_i) m_used = 0; else if (rx_hit) m_used = 1;
    endtask

    // one clock: inputs already set; sample 2 ns after the edge
    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        #1;
        chk("R1 fc_count model", fc_count_o, m_fc);
        chk("R3 rx_count model", rx_count_o, m_rx);
        chk("R7 fc_seen model", fc_seen_o, m_fc_seen);
        chk("R7 rx_seen model", rx_seen_o, m_rx_seen);
        chk("R8 fc_half model", fc_half_o, m_fc_half);
        chk("R8 rx_half model", rx_half_o, m_rx_half);
        fc_event_i = 0; bad_sym_i = 0; mgmt_wr_en_i = 0;
        fc_rd_i = 0; rx_rd_i = 0;
    endtask

    task automatic wr(bit sel, int val);
        mgmt_wr_en_i = 1; mgmt_wr_sel_i = sel; mgmt_wr_data_i = 8'(val);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R9 reset state
        chk("R9 fc_count reset", fc_count_o, 0);
        chk("R9 rx_count reset", rx_count_o, 0);
        chk("R9 latches reset", {fc_seen_o, rx_seen_o, fc_half_o, rx_half_o}, 0);
        rst_n = 1;
        tick();

        // R1 basic counting
        for (int i = 0; i < 5; i++) begin fc_event_i = 1; tick(); end
        chk("R1 five events", fc_count_o, 5);
        chk("R7 fc_seen set", fc_seen_o, 1);

        // R6 clear on read, R7 latch clears on own read
        fc_rd_i = 1; tick();
        chk("R6 read clears fc", fc_count_o, 0);
        chk("R7 fc_seen cleared", fc_seen_o, 0);

        // R8 half crossing
        wr(0, 8'h7E);
        chk("R5 write fc", fc_count_o, 8'h7E);
        fc_event_i = 1; tick();
        chk("R8 no pulse at 7F", fc_half_o, 0);
        fc_event_i = 1; tick();
        chk("R8 half value", fc_count_o, 8'h80);
        chk("R8 half pulse", fc_half_o, 1);
        tick();
        chk("R8 pulse one cycle", fc_half_o, 0);
        wr(0, 8'h7F); wr(0, 8'h80);
        chk("R8 write 80 no pulse", fc_half_o, 0);

        // R2 saturation
        wr(0, 8'hFE);
        for (int i = 0; i < 3; i++) begin fc_event_i = 1; tick(); end
        chk("R2 fc saturates", fc_count_o, 255);

        // R6 read with event
        fc_rd_i = 1; fc_event_i = 1; tick();
        chk("R6 read+event gives 1", fc_count_o, 1);
        chk("R7 read+event keeps seen", fc_seen_o, 1);

        // R3 once per carrier
        wr(1, 8'hFD);
        carrier_ok_i = 1;
        for (int i = 0; i < 4; i++) begin bad_sym_i = 1; tick(); end
        chk("R3 once per carrier", rx_count_o, 8'hFE);
        carrier_ok_i = 0; tick();
        carrier_ok_i = 1; bad_sym_i = 1; tick();
        chk("R3 new carrier counts", rx_count_o, 8'hFF);
        carrier_ok_i = 0; tick();
        carrier_ok_i = 1; bad_sym_i = 1; tick();
        chk("R2 rx saturates", rx_count_o, 8'hFF);
        chk("R7 rx_seen set at saturation", rx_seen_o, 1);

        // R7 other counter read or write leaves latch
        fc_rd_i = 1; tick();
        chk("R7 fc read keeps rx_seen", rx_seen_o, 1);
        wr(1, 3);
        chk("R7 write keeps rx_seen", rx_seen_o, 1);
        rx_rd_i = 1; tick();
        chk("R6 rx read clears", rx_count_o, 0);
        chk("R7 rx_seen cleared", rx_seen_o, 0);

        // R4 collision
        carrier_ok_i = 0; tick();
        carrier_ok_i = 1; collision_i = 1;
        bad_sym_i = 1; tick();
        bad_sym_i = 1; tick();
        chk("R4 collision not counted", rx_count_o, 0);
        chk("R4 collision no latch", rx_seen_o, 0);
        collision_i = 0; bad_sym_i = 1; tick();
        chk("R4 count still available", rx_count_o, 1);

        // R5 write beats read and event; other counter untouched
        wr(0, 9);
        mgmt_wr_en_i = 1; mgmt_wr_sel_i = 1; mgmt_wr_data_i = 8'h42;
        rx_rd_i = 1; fc_event_i = 1; tick();
        chk("R5 write wins", rx_count_o, 8'h42);
        chk("R5 other counter", fc_count_o, 10);
        carrier_ok_i = 0; tick();

        // random mix against model
        for (int i = 0; i < 6000; i++) begin
            fc_event_i   = ($urandom_range(3) == 0);
            bad_sym_i    = ($urandom_range(2) == 0);
            if ($urandom_range(7) == 0) carrier_ok_i = ~carrier_ok_i;
            if ($urandom_range(9) == 0) collision_i = ~collision_i;
            fc_rd_i      = ($urandom_range(40) == 0);
            rx_rd_i      = ($urandom_range(40) == 0);
            mgmt_wr_en_i = ($urandom_range(60) == 0);
            mgmt_wr_sel_i = 1'($urandom_range(1));
            mgmt_wr_data_i = ($urandom_range(1) == 0) ? 8'h7C : 8'($urandom);
            tick();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule